// File: doc/BRIEF.md
# PTP Transmit Timestamp Capture Unit

This block sits beside a transmit frame path and takes care of precision time protocol timestamping for each outgoing frame. When the client starts a frame it presents a 2-bit operation code and a 16-bit tag on the request port. The block queues that request in a small tag FIFO. When the start of the same frame later crosses the capture plane, the block takes the oldest queued request, latches the 80-bit system timer, and acts on the operation code.

A two-step request produces a one-cycle report strobe. The strobe carries the captured time and the client tag, and the frame stays as it is. A one-step request produces a one-cycle insertion strobe, with the captured time for the downstream logic that edits the frame. A no-action request and a reserved request take no timestamp and give no strobe.

Two sticky status bits flag misuse of the FIFO:
- A request arriving while the FIFO is full sets the write error.
- A capture event arriving while the FIFO is empty sets the read error.

Only a reset of the transmit path clears either bit.

Top module: `ptp_tx_tsu`

## Requirements
- R1: While reset is asserted and right after it is released, `rpt_valid`, `ins_valid`, `fifo_wr_err` and `fifo_rd_err` are 0 and the FIFO holds no request.
- R2: Operation code 2'b10 (two-step) is handled as follows when its capture event is sampled on a clock edge. In the cycle after that edge, `rpt_valid` is 1 for exactly one cycle. In the same cycle, `ts_out` equals the `timer_in` value sampled on that edge, and `tag_out` equals the tag queued with the request.
- R3: Operation code 2'b01 (one-step) is handled as follows. In the cycle after its capture edge, `ins_valid` is 1 for one cycle and `ts_out` holds the sampled timer. `rpt_valid` stays 0.
- R4: Operation codes 2'b00 (no action) and 2'b11 (reserved) behave identically. Neither strobe is raised, and `ts_out` and `tag_out` keep the values of the last timestamped frame.
- R5: Capture events consume requests in the order the requests were made. Up to `FIFO_DEPTH` (default 8) requests may be pending.
- R6: A request made while `FIFO_DEPTH` requests are pending, with no capture event in the same cycle, is discarded. It also sets `fifo_wr_err` from the next cycle on.
- R7: A capture event while no request is pending raises no strobe and sets `fifo_rd_err` from the next cycle on. This holds even if a request arrives in the same cycle.
- R8: `fifo_wr_err` and `fifo_rd_err` stay 1 until `rst_n` is asserted, and reset clears both.
- R9: A request and a capture event in the same cycle while the FIFO is full are both accepted. Neither error is set.
- R10: `ts_out` keeps the timer's field layout unchanged: seconds in bits [79:32] and nanoseconds in bits [31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low transmit path reset |
| req_sop | input | 1 | Client start of frame, queues a request |
| req_op | input | 2 | Operation code: 00 none, 01 one-step, 10 two-step, 11 reserved |
| req_tag | input | 16 | Client tag for the frame |
| cap_sop | input | 1 | Start of frame crosses the capture plane |
| timer_in | input | 80 | System timer, seconds [79:32], nanoseconds [31:0] |
| rpt_valid | output | 1 | One-cycle two-step report strobe |
| ins_valid | output | 1 | One-cycle one-step insertion strobe |
| tag_out | output | 16 | Tag of the last timestamped frame |
| ts_out | output | 80 | Captured time of the last timestamped frame |
| fifo_wr_err | output | 1 | Sticky FIFO overflow flag |
| fifo_rd_err | output | 1 | Sticky FIFO underflow flag |

## Verification
A wrong FIFO pointer or count shows up at the ports one cycle after the next capture event. A stale entry gives a report whose tag is not the one the client queued. A lost or extra entry leads to a missing strobe or to a spurious `fifo_rd_err`. A wrong operation decode shows in that same cycle as the wrong strobe, or as a change in `ts_out` where the value should have been held. Error flags that fail to stick show up on the very next cycle, because no later traffic may clear them.

// File: rtl/ptp_tsu_pkg.sv
package ptp_tsu_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ONE  = 2'b01,
    OP_TWO  = 2'b10,
    OP_RSVD = 2'b11
  } ptp_op_e;

  typedef struct packed {
    logic take_ts;
    logic two_step;
  } op_act_t;

  function automatic op_act_t decode_op(input logic [1:0] code);
    op_act_t a;
    a = '0;
    unique case (code)
      OP_ONE:  a.take_ts = 1'b1;
      OP_TWO:  begin a.take_ts = 1'b1; a.two_step = 1'b1; end
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/tsu_tag_fifo.sv
module tsu_tag_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             wr_err,
  output logic             rd_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_err_q, wr_err_d, rd_err_q, rd_err_d;
  logic          pop_ok, push_ok;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    wr_err_d = wr_err_q;
    rd_err_d = rd_err_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (push && !push_ok) wr_err_d = 1'b1;
    if (pop && !pop_ok)   rd_err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      wr_err_q <= 1'b0;
      rd_err_q <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      wr_err_q <= wr_err_d;
      rd_err_q <= rd_err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= din;
  end

  assign dout   = mem[rd_ptr_q];
  assign count  = cnt_q;
  assign wr_err = wr_err_q;
  assign rd_err = rd_err_q;

endmodule

// File: rtl/tsu_op_decode.sv
module tsu_op_decode (
  input  logic       fire,
  input  logic [1:0] op,
  output logic       take_ts,
  output logic       two_step,
  output logic       one_step
);
  import ptp_tsu_pkg::*;
  op_act_t act;

  always_comb begin
    act      = decode_op(op);
    take_ts  = fire && act.take_ts;
    two_step = fire && act.take_ts && act.two_step;
    one_step = fire && act.take_ts && !act.two_step;
  end
endmodule

// File: rtl/tsu_report_reg.sv
module tsu_report_reg #(
  parameter int TAG_W = 16,
  parameter int TS_W  = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_ts,
  input  logic             two_step,
  input  logic             one_step,
  input  logic [TAG_W-1:0] tag,
  input  logic [TS_W-1:0]  timer,
  output logic             rpt_valid,
  output logic             ins_valid,
  output logic [TAG_W-1:0] tag_out,
  output logic [TS_W-1:0]  ts_out
);
  logic             rpt_q, ins_q;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [TS_W-1:0]  ts_q, ts_d;

  always_comb begin
    tag_d = tag_q;
    ts_d  = ts_q;
    if (take_ts) begin
      tag_d = tag;
      ts_d  = timer;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_q <= 1'b0;
      ins_q <= 1'b0;
      tag_q <= '0;
      ts_q  <= '0;
    end else begin
      rpt_q <= two_step;
      ins_q <= one_step;
      if (take_ts) begin
        tag_q <= tag_d;
        ts_q  <= ts_d;
      end
    end
  end

  assign rpt_valid = rpt_q;
  assign ins_valid = ins_q;
  assign tag_out   = tag_q;
  assign ts_out    = ts_q;
endmodule

// File: rtl/ptp_tx_tsu.sv
module ptp_tx_tsu #(
  parameter int TAG_W      = 16,
  parameter int TS_W       = 80,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_sop,
  input  logic [1:0]       req_op,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             cap_sop,
  input  logic [TS_W-1:0]  timer_in,
  output logic             rpt_valid,
  output logic             ins_valid,
  output logic [TAG_W-1:0] tag_out,
  output logic [TS_W-1:0]  ts_out,
  output logic             fifo_wr_err,
  output logic             fifo_rd_err
);
  localparam int EW = TAG_W + 2;
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [EW-1:0] head;
  logic          fifo_empty, fifo_full;
  logic [CW-1:0] fifo_count;
  logic          cap_fire, take_ts, two_step, one_step;

  tsu_tag_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(EW)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (req_sop),
    .din    ({req_op, req_tag}),
    .pop    (cap_sop),
    .dout   (head),
    .empty  (fifo_empty),
    .full   (fifo_full),
    .count  (fifo_count),
    .wr_err (fifo_wr_err),
    .rd_err (fifo_rd_err)
  );

  assign cap_fire = cap_sop && !fifo_empty;

  tsu_op_decode u_dec (
    .fire     (cap_fire),
    .op       (head[EW-1 -: 2]),
    .take_ts  (take_ts),
    .two_step (two_step),
    .one_step (one_step)
  );

  tsu_report_reg #(.TAG_W(TAG_W), .TS_W(TS_W)) u_rpt (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_ts   (take_ts),
    .two_step  (two_step),
    .one_step  (one_step),
    .tag       (head[TAG_W-1:0]),
    .timer     (timer_in),
    .rpt_valid (rpt_valid),
    .ins_valid (ins_valid),
    .tag_out   (tag_out),
    .ts_out    (ts_out)
  );
endmodule

// File: rtl/ptp_tx_tsu_chk.sv
module ptp_tx_tsu_chk #(
  parameter int TS_W       = 80,
  parameter int FIFO_DEPTH = 8,
  parameter int CW         = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_sop,
  input logic            cap_sop,
  input logic [TS_W-1:0] timer_in,
  input logic            rpt_valid,
  input logic            ins_valid,
  input logic [TS_W-1:0] ts_out,
  input logic            fifo_wr_err,
  input logic            fifo_rd_err,
  input logic            fifo_empty,
  input logic            fifo_full,
  input logic [CW-1:0]   fifo_count
);
  a_r2_rpt_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> $past(cap_sop));
  a_r2_rpt_ts_match: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> ts_out == $past(timer_in));
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rpt_valid && ins_valid));
  a_r4_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpt_valid && !ins_valid) |-> $stable(ts_out) || $past(!rst_n));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(FIFO_DEPTH));
  a_r6_wr_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sop && fifo_full && !cap_sop) |=> fifo_wr_err);
  a_r7_rd_err_nostrobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_sop && fifo_empty) |=> fifo_rd_err && !rpt_valid && !ins_valid);
  a_r8_wr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_err |=> fifo_wr_err);
  a_r8_rd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_err |=> fifo_rd_err);
  a_r9_full_both: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sop && cap_sop && fifo_full && !fifo_wr_err) |=> !fifo_wr_err && fifo_full);
endmodule

bind ptp_tx_tsu ptp_tx_tsu_chk #(
  .TS_W(TS_W), .FIFO_DEPTH(FIFO_DEPTH), .CW($clog2(FIFO_DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_sop(req_sop), .cap_sop(cap_sop),
  .timer_in(timer_in), .rpt_valid(rpt_valid), .ins_valid(ins_valid),
  .ts_out(ts_out), .fifo_wr_err(fifo_wr_err), .fifo_rd_err(fifo_rd_err),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count)
);

// File: tb/test_ptp_tx_tsu.sv
module test_ptp_tx_tsu;
  logic        clk;
  logic        rst_n;
  logic        req_sop;
  logic [1:0]  req_op;
  logic [15:0] req_tag;
  logic        cap_sop;
  logic [79:0] timer_in;
  logic        rpt_valid, ins_valid, fifo_wr_err, fifo_rd_err;
  logic [15:0] tag_out;
  logic [79:0] ts_out;

  int checks = 0;
  int errors = 0;
  logic [79:0] last_ts;
  logic [15:0] last_tag;

  ptp_tx_tsu i_ptp_tx_tsu (
    .clk(clk), .rst_n(rst_n), .req_sop(req_sop), .req_op(req_op),
    .req_tag(req_tag), .cap_sop(cap_sop), .timer_in(timer_in),
    .rpt_valid(rpt_valid), .ins_valid(ins_valid), .tag_out(tag_out),
    .ts_out(ts_out), .fifo_wr_err(fifo_wr_err), .fifo_rd_err(fifo_rd_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: {op, tag, timer}; seconds in [79:32], ns in [31:0]
  localparam int NV = 6;
  localparam logic [97:0] VEC [NV] = '{
    {2'b10, 16'h1234, 48'h0000_0000_0001, 32'h0000_0010},
    {2'b01, 16'hBEEF, 48'h0000_0000_0002, 32'h3B9A_C9FF},
    {2'b00, 16'h0F0F, 48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF},
    {2'b10, 16'hA5A5, 48'h8000_0000_0000, 32'h0000_0001},
    {2'b11, 16'h5A5A, 48'h1111_2222_3333, 32'h4444_5555},
    {2'b10, 16'hFFFF, 48'hCAFE_0000_BEEF, 32'h1234_5678}
  };

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    req_sop = 0; req_op = 0; req_tag = 0; cap_sop = 0; timer_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    last_ts = '0; last_tag = '0;
  endtask

  task automatic push(input logic [1:0] op, input logic [15:0] tag);
    req_sop = 1; req_op = op; req_tag = tag;
    @(negedge clk);
    req_sop = 0;
  endtask

  // capture then check strobes in the following cycle
  task automatic capture(input logic [79:0] t, input logic [1:0] op, input logic [15:0] tag);
    cap_sop = 1; timer_in = t;
    @(negedge clk);
    cap_sop = 0; timer_in = ~t;
    if (op == 2'b10 || op == 2'b01) begin last_ts = t; last_tag = tag; end
    chk("R2 rpt_valid", 80'(rpt_valid), 80'(op == 2'b10));
    chk("R3 ins_valid", 80'(ins_valid), 80'(op == 2'b01));
    chk("R2/R4/R10 ts_out", ts_out, last_ts);
    chk("R2/R4 tag_out", 80'(tag_out), 80'(last_tag));
    @(negedge clk);
    chk("R2 single pulse", 80'({rpt_valid, ins_valid}), 80'(0));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req_sop = 0; req_op = 0; req_tag = 0; cap_sop = 0; timer_in = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R1 strobes in reset", 80'({rpt_valid, ins_valid}), 80'(0));
    do_reset();
    chk("R1 strobes after reset", 80'({rpt_valid, ins_valid}), 80'(0));
    chk("R1 errors after reset", 80'({fifo_wr_err, fifo_rd_err}), 80'(0));

    // table walk: one frame at a time (R2, R3, R4, R10)
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][97:96], VEC[i][95:80]);
      capture(VEC[i][79:0], VEC[i][97:96], VEC[i][95:80]);
    end
    chk("R1 no errors after table", 80'({fifo_wr_err, fifo_rd_err}), 80'(0));

    // R5: ordering with several pending
    push(2'b10, 16'h0A01);
    push(2'b01, 16'h0A02);
    push(2'b10, 16'h0A03);
    capture(80'h100, 2'b10, 16'h0A01);
    capture(80'h200, 2'b01, 16'h0A02);
    capture(80'h300, 2'b10, 16'h0A03);
    chk("R5 tag order last", 80'(tag_out), 80'h0A03);

    // R7: pop on empty, even with a same-cycle request
    req_sop = 1; req_op = 2'b10; req_tag = 16'h7777;
    cap_sop = 1; timer_in = 80'h999;
    @(negedge clk);
    req_sop = 0; cap_sop = 0;
    chk("R7 no strobe on empty", 80'({rpt_valid, ins_valid}), 80'(0));
    chk("R7 rd_err set", 80'(fifo_rd_err), 80'(1));
    chk("R7 ts held", ts_out, last_ts);
    capture(80'hABC, 2'b10, 16'h7777);
    chk("R8 rd_err sticky", 80'(fifo_rd_err), 80'(1));

    // R8: reset clears
    do_reset();
    chk("R8 reset clears", 80'({fifo_wr_err, fifo_rd_err}), 80'(0));

    // R9: full plus simultaneous push and pop
    for (int k = 0; k < 8; k++) push(2'b10, 16'hC000 + 16'(k));
    req_sop = 1; req_op = 2'b10; req_tag = 16'hC008;
    cap_sop = 1; timer_in = 80'h5000;
    @(negedge clk);
    req_sop = 0; cap_sop = 0;
    chk("R9 pop while full", 80'(tag_out), 80'hC000);
    chk("R9 no wr_err", 80'(fifo_wr_err), 80'(0));
    last_ts = 80'h5000; last_tag = 16'hC000;
    for (int k = 1; k <= 8; k++)
      capture(80'h5000 + 80'(k), 2'b10, 16'hC000 + 16'(k));
    chk("R9 no rd_err", 80'(fifo_rd_err), 80'(0));

    // R6: overflow drops request and sets sticky write error
    do_reset();
    for (int k = 0; k < 8; k++) push(2'b10, 16'hD000 + 16'(k));
    chk("R6 no wr_err at 8", 80'(fifo_wr_err), 80'(0));
    push(2'b10, 16'hDEAD);
    chk("R6 wr_err set", 80'(fifo_wr_err), 80'(1));
    for (int k = 0; k < 8; k++)
      capture(80'h6000 + 80'(k), 2'b10, 16'hD000 + 16'(k));
    chk("R6 dropped entry absent", 80'(fifo_rd_err), 80'(0));
    cap_sop = 1;
    @(negedge clk);
    cap_sop = 0;
    chk("R6 nothing left", 80'(rpt_valid), 80'(0));
    chk("R8 wr_err sticky", 80'({fifo_wr_err, fifo_rd_err}), 80'(3));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule